// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models a two-wire serial EEPROM of 4096 bytes as a synthesizable slave that runs on a fast system clock. The serial clock and data lines are oversampled and synchronized inside the block. Bus start and stop conditions are recovered from them, and the device-address byte is matched against a fixed 4-bit family code and three strap inputs. The slave answers only on the data line, and only by pulling it low. A single output enable drives the open-drain pad.

Writes go through a page buffer that holds up to one page of 32 bytes. The buffer is copied into the storage array only when a STOP ends the command. After that STOP a self-timed program cycle runs, and while it runs the slave refuses its own address. A master can therefore poll for completion. A write-protect input stops the program cycle from starting. Reads come from an internal address counter, which a dummy write can load, and they continue through the whole array, wrapping from the last byte to the first.

Top module: `ee2w_slave`

## Requirements
- R1: Every command begins with a START (data falls while the clock is high). The first byte after START is compared with `{4'b1010, dev_strap[2:0], rw}`, most significant bit first. A mismatch gets no acknowledge, and the slave keeps the data line released until the next START.
- R2: For every byte it accepts, the slave pulls the data line low during the 9th clock high phase.
- R3: A write with `rw = 0` carries two address bytes, of which the low 12 bits form the byte address, followed by data. A single data byte changes only the addressed location. The other bytes of the same page keep their contents.
- R4: In a page write, each data byte goes to the current address and then increments only the low 5 address bits. After byte 31 of the page the next byte wraps to byte 0 of the same page, and the upper 7 bits never change.
- R5: A STOP that ends a write with at least one data byte starts a program cycle of `PROG_CYCLES` clocks. During that cycle a device-address byte gets no acknowledge. After the cycle ends the written data reads back.
- R6: When `wr_prot` is high at the STOP, no program cycle starts, the array is unchanged, and the next device-address byte is acknowledged at once. Data bytes are still acknowledged while write protection is on.
- R7: A repeated START after the address bytes and before any data byte abandons the write, so no program cycle starts. The address counter keeps the loaded address, and a read that follows returns the byte at that address.
- R8: In a read, each master acknowledge makes the slave send the byte at the next address. After address 0xFFF the next address is 0x000. A master non-acknowledge releases the line and ends the read.
- R9: A read that is not preceded by an address load starts at the address that follows the last byte sent or written.
- R10: The slave changes its data-line drive only while the serial clock is low. It releases the line after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level (wired bus value) |
| dev_strap | input | 3 | Device-address strap bits, tie low if unused |
| wr_prot | input | 1 | High blocks all programming, tie low if unused |
| sda_pull_low | output | 1 | Open-drain enable: high pulls the data line low |

## Verification
A wrong address counter shows at the pins in the very next data byte a read returns, either as the wrong value or as a failure to wrap at the array end. A bad page-rollover carry shows only when the neighbouring page is read back. A program timer that is stuck or skipped shows within one device-address byte: a polling master gets an acknowledge it should not get, or gets no acknowledge for far longer than `PROG_CYCLES`. A commit that went wrong stays hidden until the locations are read back, so every write test ends with a read-back that also covers an untouched neighbouring byte.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_RX, PH_RXACK, PH_TX, PH_TXACK} phase_t;
  typedef enum logic [1:0] {K_DEV, K_AHI, K_ALO, K_DATA} kind_t;
endpackage

// File: rtl/ee2w_line_sync.sv
module ee2w_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
    end
  end

  assign scl_lvl   = scl_sy[1];
  assign sda_lvl   = sda_sy[1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/ee2w_array.sv
module ee2w_array #(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ee2w_page_buf.sv
module ee2w_page_buf #(
  parameter int PAGE = 32,
  localparam int PW = $clog2(PAGE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [PW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  output logic          any_valid
);
  logic [7:0]      bytes_q [PAGE];
  logic [PAGE-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (wr_en) bytes_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) mask_q <= '0;
    else if (wr_en) mask_q[wr_idx] <= 1'b1;
  end

  assign rd_data   = bytes_q[rd_idx];
  assign rd_valid  = mask_q[rd_idx];
  assign any_valid = |mask_q;
endmodule

// File: rtl/ee2w_prog_timer.sv
module ee2w_prog_timer #(
  parameter int PROG_CYCLES = 400,
  parameter int PAGE = 32,
  localparam int PW = $clog2(PAGE),
  localparam int CW = $clog2(PROG_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  output logic          busy,
  output logic          done,
  output logic [PW-1:0] idx,
  output logic          idx_live
);
  logic [CW-1:0] left_q;
  logic [PW:0]   step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      step_q <= '0;
    end else if (go) begin
      left_q <= CW'(PROG_CYCLES);
      step_q <= '0;
    end else if (left_q != '0) begin
      left_q <= left_q - CW'(1);
      if (!step_q[PW]) step_q <= step_q + 1'b1;
    end
  end

  assign busy     = (left_q != '0);
  assign done     = (left_q == CW'(1));
  assign idx      = step_q[PW-1:0];
  assign idx_live = busy && !step_q[PW];

  // R5: every page slot is visited before the cycle ends
  assert_commit_in_window_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(step_q[PW]));
endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
  import ee2w_pkg::*;
#(
  parameter int         MEM_BYTES   = 4096,
  parameter int         PAGE_BYTES  = 32,
  parameter int         PROG_CYCLES = 400,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] dev_strap,
  input  logic       wr_prot,
  output logic       sda_pull_low
);
  localparam int AW  = $clog2(MEM_BYTES);
  localparam int PW  = $clog2(PAGE_BYTES);
  localparam int HIW = AW - 8;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  phase_t         phase_q;
  kind_t          kind_q;
  logic [3:0]     cnt_q;
  logic [7:0]     sh_q;
  logic [AW-1:0]  addr_q;
  logic [HIW-1:0] ahi_q;
  logic           rw_q, low_q;
  logic [7:0]     mem_q, pb_rd;
  logic           pb_we, pb_clr, pb_valid, pb_any;
  logic           prog_go, busy, prog_done, tm_live;
  logic [PW-1:0]  tm_idx;

  ee2w_line_sync u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  assign pb_we   = (phase_q == PH_RX) && scl_fall && (cnt_q == 4'd8) && (kind_q == K_DATA)
                   && !start_det && !stop_det;
  assign prog_go = stop_det && pb_any && !wr_prot && !busy;
  assign pb_clr  = ((start_det || (stop_det && !prog_go)) && !busy) || prog_done;

  ee2w_page_buf #(.PAGE(PAGE_BYTES)) u_pbuf (
    .clk(clk), .rst(rst), .clr(pb_clr), .wr_en(pb_we), .wr_idx(addr_q[PW-1:0]),
    .wr_data(sh_q), .rd_idx(tm_idx), .rd_data(pb_rd), .rd_valid(pb_valid), .any_valid(pb_any));

  ee2w_prog_timer #(.PROG_CYCLES(PROG_CYCLES), .PAGE(PAGE_BYTES)) u_timer (
    .clk(clk), .rst(rst), .go(prog_go), .busy(busy), .done(prog_done),
    .idx(tm_idx), .idx_live(tm_live));

  ee2w_array #(.DEPTH(MEM_BYTES)) u_array (
    .clk(clk), .we(tm_live && pb_valid), .waddr({addr_q[AW-1:PW], tm_idx}),
    .wdata(pb_rd), .raddr(addr_q), .rdata(mem_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      kind_q  <= K_DEV;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      ahi_q   <= '0;
      rw_q    <= 1'b0;
      low_q   <= 1'b0;
    end else if (start_det) begin
      phase_q <= PH_RX;
      kind_q  <= K_DEV;
      cnt_q   <= '0;
      low_q   <= 1'b0;
    end else if (stop_det) begin
      phase_q <= PH_IDLE;
      low_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_RX: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_lvl};
            cnt_q <= cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            low_q   <= 1'b1;
            phase_q <= PH_RXACK;
            unique case (kind_q)
              K_DEV: begin
                rw_q <= sh_q[0];
                if (sh_q[7:1] != {DEV_CODE, dev_strap} || busy) begin
                  low_q   <= 1'b0;
                  phase_q <= PH_IDLE;
                end
              end
              K_AHI:   ahi_q  <= sh_q[HIW-1:0];
              K_ALO:   addr_q <= {ahi_q, sh_q};
              default: addr_q[PW-1:0] <= addr_q[PW-1:0] + 1'b1;
            endcase
          end
        end
        PH_RXACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (kind_q == K_DEV && rw_q) begin
              sh_q    <= mem_q;
              low_q   <= ~mem_q[7];
              addr_q  <= addr_q + 1'b1;
              phase_q <= PH_TX;
            end else begin
              low_q   <= 1'b0;
              phase_q <= PH_RX;
              unique case (kind_q)
                K_DEV:   kind_q <= K_AHI;
                K_AHI:   kind_q <= K_ALO;
                default: kind_q <= K_DATA;
              endcase
            end
          end
        end
        PH_TX: begin
          if (scl_rise) cnt_q <= cnt_q + 4'd1;
          else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              low_q   <= 1'b0;
              phase_q <= PH_TXACK;
            end else begin
              low_q <= ~sh_q[6];
              sh_q  <= {sh_q[6:0], 1'b0};
            end
          end
        end
        PH_TXACK: begin
          if (scl_rise && sda_lvl) phase_q <= PH_IDLE;
          else if (scl_fall) begin
            sh_q    <= mem_q;
            low_q   <= ~mem_q[7];
            addr_q  <= addr_q + 1'b1;
            cnt_q   <= '0;
            phase_q <= PH_TX;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_low = low_q;

  // R10: drive on the data line moves only while the clock is low
  assert_sda_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(low_q) |-> !scl_lvl);
  // R5: a program cycle is only ever launched by a STOP
  assert_prog_after_stop_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_det));
  // R6: write protection keeps the program cycle from starting
  assert_wp_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(wr_prot));
  // R4: data bytes never carry into the page number
  assert_page_fixed_R4: assert property (@(posedge clk) disable iff (rst)
    (kind_q == K_DATA && $past(kind_q) == K_DATA) |-> addr_q[AW-1:PW] == $past(addr_q[AW-1:PW]));
endmodule

// File: tb/ee2w_slave_tb.sv
module ee2w_slave_tb;
  localparam int Q = 8;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic pull_low;
  logic sda_bus;
  int   n_chk = 0, n_err = 0, hi_moves = 0;
  bit   finished = 1'b0;
  logic [7:0] rbuf [4];

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~pull_low;

  ee2w_slave u_dut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus),
    .dev_strap(STRAP), .wr_prot(wp), .sda_pull_low(pull_low));

  // R10 monitor: the slave drive must not move while the master holds the clock high
  logic prev_low = 1'b0;
  always @(negedge clk) begin
    if (!rst && scl_m && pull_low != prev_low) hi_moves++;
    prev_low = pull_low;
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    qw(); sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw(); qw();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_bus; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(~give_ack);
  endtask

  task automatic wait_ready(string tag);
    logic a;
    int tries = 0;
    do begin
      bus_start(); send_byte({4'b1010, STRAP, 1'b0}, a); bus_stop(); tries++;
    end while (!a && tries < 20);
    check(tag, int'(a), 1);
  endtask

  // address load then read of n bytes
  task automatic rand_read(input logic [11:0] ad, input int n, string tag);
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, a); check(tag, int'(a), 1);
    send_byte({4'b0000, ad[11:8]}, a);
    send_byte(ad[7:0], a);
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, a); check(tag, int'(a), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      rbuf[i] = d;
    end
    bus_stop();
  endtask

  task automatic t_reset();
    check("R10 reset release", int'(pull_low), 0);
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start(); send_byte({4'b1010, 3'b010, 1'b0}, a); bus_stop();
    check("R1 wrong strap nack", int'(a), 0);
    bus_start(); send_byte({4'b1011, STRAP, 1'b0}, a); bus_stop();
    check("R1 wrong family nack", int'(a), 0);
  endtask

  task automatic t_byte_write();
    logic a;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, a); check("R2 dev ack", int'(a), 1);
    send_byte(8'h00, a); check("R2 addr hi ack", int'(a), 1);
    send_byte(8'h01, a); check("R2 addr lo ack", int'(a), 1);
    send_byte(8'h5A, a); check("R2 data ack", int'(a), 1);
    bus_stop();
    bus_start(); send_byte({4'b1010, STRAP, 1'b0}, a); bus_stop();
    check("R5 busy nack", int'(a), 0);
    wait_ready("R5 cycle ends");
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, a); send_byte(8'h00, a);
    send_byte(8'h00, a); send_byte(8'hA5, a);
    bus_stop();
    wait_ready("R5 cycle ends");
    rand_read(12'h001, 1, "R3 read ack");
    check("R3 first byte kept", int'(rbuf[0]), 'h5A);
    rand_read(12'h000, 1, "R3 read ack");
    check("R3 second byte", int'(rbuf[0]), 'hA5);
  endtask

  task automatic t_page_roll();
    logic a;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, a); send_byte(8'h0F, a); send_byte(8'hFE, a);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a); send_byte(8'h44, a);
    check("R4 page data ack", int'(a), 1);
    bus_stop();
    wait_ready("R5 page cycle ends");
    rand_read(12'hFE0, 2, "R4 read ack");
    check("R4 rollover byte0", int'(rbuf[0]), 'h33);
    check("R4 rollover byte1", int'(rbuf[1]), 'h44);
  endtask

  task automatic t_seq_wrap();
    rand_read(12'hFFE, 3, "R8 read ack");
    check("R8 seq FFE", int'(rbuf[0]), 'h11);
    check("R8 seq FFF", int'(rbuf[1]), 'h22);
    check("R8 wrap to 000", int'(rbuf[2]), 'hA5);
  endtask

  task automatic t_current();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, a); check("R9 dev read ack", int'(a), 1);
    recv_byte(1'b0, d);
    bus_stop();
    check("R9 current address", int'(d), 'h5A);
  endtask

  task automatic t_protect();
    logic a;
    wp = 1'b1;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, a); send_byte(8'h00, a); send_byte(8'h01, a);
    send_byte(8'hFF, a); check("R6 data ack under protect", int'(a), 1);
    bus_stop();
    bus_start(); send_byte({4'b1010, STRAP, 1'b0}, a); bus_stop();
    check("R6 no program cycle", int'(a), 1);
    wp = 1'b0;
    rand_read(12'h001, 1, "R6 read ack");
    check("R6 array unchanged", int'(rbuf[0]), 'h5A);
  endtask

  task automatic t_abandon();
    logic a;
    rand_read(12'h000, 1, "R7 read ack");
    check("R7 random read", int'(rbuf[0]), 'hA5);
    bus_start(); send_byte({4'b1010, STRAP, 1'b0}, a); bus_stop();
    check("R7 no program after dummy write", int'(a), 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_mismatch();
    t_byte_write();
    t_page_roll();
    t_seq_wrap();
    t_current();
    t_protect();
    t_abandon();
    check("R10 drive moved with clock high", hi_moves, 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule